// File: doc/BRIEF.md
# Periodic Rate Generator with Event Flags

The block turns a 32.768 kHz reference level, sampled in the system clock domain, into thirteen binary-divided taps. A 4-bit rate code picks one tap. The chosen tap drives a square-wave pin. Each full period of that tap also raises a periodic event. A 3-bit oscillator mode decides whether the divider counts, is held cleared, or counts and also allows the status register to be written. In the writable mode a 32 kHz enable bit may be set, and the square-wave pin then carries the reference level directly.

The block also holds the event status register. That register latches the periodic event, an alarm event and an update-ended event, both of which come from the calendar logic outside. It applies one enable bit per source. It keeps a sticky aggregate request flag, which drives an active-low request pin meant for an open-drain pad. A host read of the status register clears every flag and releases the request pin. A small control register holds the square-wave enable, the three interrupt enables and an update-transfer-inhibit bit. Setting the inhibit bit forces the update interrupt enable to 0.

Top module: `prg_event_unit`

## Requirements
- R1: Rate code selects the square-wave tap. Code 0 gives a constant 0. Code 1 gives reference/128 and code 2 gives reference/256. A code c from 3 to 15 gives reference/2^(c-1), so code 3 gives 8.192 kHz and code 15 gives 2 Hz.
- R2: The periodic flag (status bit 6) is set once per period of the selected tap, which is 2^(c-1) reference periods for codes 3 to 15, and never for code 0.
- R3: When the square-wave enable (control bit 0) is 0, sqw_out is 0.
- R4: The divider counts only when osc_mode is 3'b010 or 3'b011. For any other value it is held cleared, so no periodic event occurs and the tap stays low.
- R5: The 32 kHz enable (status bit 2) is loaded from k32_wdata by stat_wr only while osc_mode is 3'b011. It is cleared in any cycle in which osc_mode differs from 3'b011.
- R6: When the square-wave enable and the 32 kHz enable are both 1, sqw_out follows the synchronized reference level. Periodic event timing still follows the rate code.
- R7: The aggregate flag (status bit 7) is set in the cycle after any flag is set while its enable is 1. The enables are periodic = control bit 3, alarm = control bit 2, and update = control bit 1 with control bit 4 at 0. irq_n is low exactly while the aggregate flag is 1.
- R8: A stat_rd strobe clears status bits 7, 6, 5 and 4 in the next cycle and leaves bit 2 unchanged. Status bits 0, 1 and 3 always read 0.
- R9: A control write with bit 4 (transfer inhibit) at 1 stores bit 1 (update enable) as 0. While inhibit is 1, update events set the update flag (bit 4) but raise no request.
- R10: An event in the same cycle as a stat_rd leaves its flag set afterwards.
- R11: After reset, the status and control registers read 0, irq_n is 1 and sqw_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref32_lvl | input | 1 | 32.768 kHz reference waveform level |
| osc_mode | input | 3 | Oscillator/divider mode |
| rate_sel | input | 4 | Tap select code |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 5 | Control write data: [0] square enable, [1] update IE, [2] alarm IE, [3] periodic IE, [4] transfer inhibit |
| ctl_rdata | output | 5 | Control register contents |
| alarm_evt | input | 1 | One-cycle alarm event |
| update_evt | input | 1 | One-cycle update-ended event |
| stat_rd | input | 1 | Host read strobe of the status register |
| stat_wr | input | 1 | Status write strobe |
| k32_wdata | input | 1 | Value written into the 32 kHz enable |
| stat_rdata | output | 8 | Status: [7] aggregate, [6] periodic, [5] alarm, [4] update, [2] 32 kHz enable |
| sqw_out | output | 1 | Square-wave output |
| irq_n | output | 1 | Active-low request, meant for an open-drain pad |

## Verification
The rate path is run with the fastest tap, both aliased codes and the tap they alias, the slowest tap and the silent code. Each run counts square-wave rises and periodic flags over a window of whole periods, which separates a wrong tap from a wrong event period. The same rate is repeated with the square-wave enable off, with the divider held in two oscillator modes, and with the 32 kHz pass-through on, which separates output gating from event timing. The flag tests pair each event with its enable on and off, with the transfer inhibit on and off, and with a read in the same cycle.

// File: rtl/prg_pkg.sv
// Shared constants, field positions and the rate-code decoder of the
// periodic rate generator. Assumes a 4-bit rate code.
package prg_pkg;
    localparam int RATE_W    = 4;
    localparam int IDX_W     = 4;
    localparam int DIV_W_DEF = 14;
    localparam int CTL_W     = 5;
    localparam int STAT_W    = 8;

    localparam logic [2:0] OSC_RUN    = 3'b010;
    localparam logic [2:0] OSC_RUN_WR = 3'b011;

    // status register bit positions
    localparam int ST_REQ = 7;
    localparam int ST_PER = 6;
    localparam int ST_ALM = 5;
    localparam int ST_UPD = 4;
    localparam int ST_K32 = 2;

    // control register bit positions
    localparam int CT_SQW = 0;
    localparam int CT_UIE = 1;
    localparam int CT_AIE = 2;
    localparam int CT_PIE = 3;
    localparam int CT_INH = 4;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } tap_sel_t;

    // Map a rate code to the divider bit whose level forms the tap.
    function automatic tap_sel_t decode_rate(input logic [RATE_W-1:0] code);
        tap_sel_t t;
        t.valid = (code != '0);
        case (code)
            4'd0:    t.idx = '0;
            4'd1:    t.idx = 4'd6;
            4'd2:    t.idx = 4'd7;
            default: t.idx = code - 4'd2;
        endcase
        return t;
    endfunction
endpackage

// File: rtl/prg_divider.sv
// Reference synchronizer, binary divider and tap selection.
// Assumes ref_lvl is a slow waveform (several clk cycles per level) and that
// DIV_W covers the deepest tap index.
module prg_divider
    import prg_pkg::*;
#(
    parameter int DIV_W = DIV_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_lvl,
    input  logic              run,
    input  logic [RATE_W-1:0] rate_sel,
    output logic              ref_sync,
    output logic              tap_lvl,
    output logic              per_evt
);
    logic             s1_q;
    logic             s2_q;
    logic             tick;
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] low_full;
    tap_sel_t         sel;

    // Sample the reference level twice to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
        end else begin
            s1_q <= ref_lvl;
            s2_q <= s1_q;
        end
    end

    assign tick     = s1_q & ~s2_q;
    assign ref_sync = s1_q;

    // Divider counter: cleared while stopped, advanced once per reference period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + {{(DIV_W-1){1'b0}}, 1'b1};
        end
    end

    // low_full[k] is set when bits k..0 of the counter are all ones.
    assign low_full[0] = cnt_q[0];
    for (genvar k = 1; k < DIV_W; k++) begin : g_full
        assign low_full[k] = low_full[k-1] & cnt_q[k];
    end

    assign sel     = decode_rate(rate_sel);
    assign tap_lvl = sel.valid & cnt_q[sel.idx];
    assign per_evt = run & tick & sel.valid & low_full[sel.idx];
endmodule

// File: rtl/prg_ctl_reg.sv
// Control register holding the square-wave enable, the interrupt enables and
// the transfer inhibit. A write with the inhibit set stores the update enable as 0.
module prg_ctl_reg
    import prg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CTL_W-1:0] wdata,
    output logic [CTL_W-1:0] ctl_q
);
    logic [CTL_W-1:0] wval;

    // Force the update enable low when the write sets the inhibit.
    always_comb begin
        wval         = wdata;
        wval[CT_UIE] = wdata[CT_UIE] & ~wdata[CT_INH];
    end

    // Register the control fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr) begin
            ctl_q <= wval;
        end
    end
endmodule

// File: rtl/prg_event_status.sv
// Event status register: three sticky event flags, a sticky aggregate request
// flag and the 32 kHz enable. Assumes events are single-cycle pulses.
module prg_event_status
    import prg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              per_evt,
    input  logic              alarm_evt,
    input  logic              update_evt,
    input  logic              rd,
    input  logic              wr,
    input  logic              k32_wbit,
    input  logic              wr_mode,
    input  logic              en_per,
    input  logic              en_alm,
    input  logic              en_upd,
    input  logic              inhibit,
    output logic [STAT_W-1:0] status
);
    logic pf_q, af_q, uf_q, req_q, k32_q;
    logic pf_n, af_n, uf_n, req_n;
    logic keep;

    // Next flag values: a read drops old flags, a new event always lands.
    always_comb begin
        keep  = ~rd;
        pf_n  = (pf_q & keep) | per_evt;
        af_n  = (af_q & keep) | alarm_evt;
        uf_n  = (uf_q & keep) | update_evt;
        req_n = (req_q & keep)
              | (pf_n & en_per)
              | (af_n & en_alm)
              | (uf_n & en_upd & ~inhibit);
    end

    // Register the event and aggregate flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_q  <= 1'b0;
            af_q  <= 1'b0;
            uf_q  <= 1'b0;
            req_q <= 1'b0;
        end else begin
            pf_q  <= pf_n;
            af_q  <= af_n;
            uf_q  <= uf_n;
            req_q <= req_n;
        end
    end

    // 32 kHz enable: writable only in the writable mode, cleared outside it.
    always_ff @(posedge clk) begin
        if (!rst_n || !wr_mode) begin
            k32_q <= 1'b0;
        end else if (wr) begin
            k32_q <= k32_wbit;
        end
    end

    assign status = {req_q, pf_q, af_q, uf_q, 1'b0, k32_q, 2'b00};
endmodule

// File: rtl/prg_event_unit.sv
// Top level of the periodic rate generator with event flags. It ties the
// divider, control and status registers together and forms the square-wave
// and request pins. Assumes the reference level is sampled in the clk domain.
module prg_event_unit
    import prg_pkg::*;
#(
    parameter int DIV_W = DIV_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref32_lvl,
    input  logic [2:0]        osc_mode,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              ctl_wr,
    input  logic [CTL_W-1:0]  ctl_wdata,
    output logic [CTL_W-1:0]  ctl_rdata,
    input  logic              alarm_evt,
    input  logic              update_evt,
    input  logic              stat_rd,
    input  logic              stat_wr,
    input  logic              k32_wdata,
    output logic [STAT_W-1:0] stat_rdata,
    output logic              sqw_out,
    output logic              irq_n
);
    logic             div_run;
    logic             wr_mode;
    logic             ref_sync;
    logic             tap_lvl;
    logic             per_evt;
    logic [CTL_W-1:0] ctl_q;
    logic [STAT_W-1:0] status;

    assign div_run = (osc_mode == OSC_RUN) || (osc_mode == OSC_RUN_WR);
    assign wr_mode = (osc_mode == OSC_RUN_WR);

    prg_divider #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_lvl  (ref32_lvl),
        .run      (div_run),
        .rate_sel (rate_sel),
        .ref_sync (ref_sync),
        .tap_lvl  (tap_lvl),
        .per_evt  (per_evt)
    );

    prg_ctl_reg u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (ctl_wr),
        .wdata (ctl_wdata),
        .ctl_q (ctl_q)
    );

    prg_event_status u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .per_evt    (per_evt),
        .alarm_evt  (alarm_evt),
        .update_evt (update_evt),
        .rd         (stat_rd),
        .wr         (stat_wr),
        .k32_wbit   (k32_wdata),
        .wr_mode    (wr_mode),
        .en_per     (ctl_q[CT_PIE]),
        .en_alm     (ctl_q[CT_AIE]),
        .en_upd     (ctl_q[CT_UIE]),
        .inhibit    (ctl_q[CT_INH]),
        .status     (status)
    );

    assign sqw_out    = ctl_q[CT_SQW] & (status[ST_K32] ? ref_sync : tap_lvl);
    assign irq_n      = ~status[ST_REQ];
    assign ctl_rdata  = ctl_q;
    assign stat_rdata = status;
endmodule

// File: rtl/prg_event_unit_chk.sv
// Assertion checker for prg_event_unit, attached through bind.
module prg_event_unit_chk
    import prg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        osc_mode,
    input logic [CTL_W-1:0]  ctl_rdata,
    input logic              alarm_evt,
    input logic              update_evt,
    input logic              stat_rd,
    input logic [STAT_W-1:0] stat_rdata,
    input logic              sqw_out,
    input logic              irq_n
);
    logic run;
    assign run = (osc_mode == OSC_RUN) || (osc_mode == OSC_RUN_WR);

    assert_sqw_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rdata[CT_SQW] |-> !sqw_out);

    assert_no_per_when_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !stat_rdata[ST_PER]) |=> !stat_rdata[ST_PER]);

    assert_k32_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_mode != OSC_RUN_WR) |=> !stat_rdata[ST_K32]);

    assert_irq_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (stat_rdata[ST_PER] || stat_rdata[ST_ALM] || stat_rdata[ST_UPD]));

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !alarm_evt && !update_evt && !run) |=> (stat_rdata[7:4] == 4'h0));

    assert_inhibit_kills_uie_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[CT_INH] |-> !ctl_rdata[CT_UIE]);

    assert_alarm_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_evt |=> stat_rdata[ST_ALM]);

    assert_update_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
        update_evt |=> stat_rdata[ST_UPD]);
endmodule

bind prg_event_unit prg_event_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .osc_mode   (osc_mode),
    .ctl_rdata  (ctl_rdata),
    .alarm_evt  (alarm_evt),
    .update_evt (update_evt),
    .stat_rd    (stat_rd),
    .stat_rdata (stat_rdata),
    .sqw_out    (sqw_out),
    .irq_n      (irq_n)
);

// File: tb/prg_event_unit_bench.sv
// Bench: behavioural reference model compared every cycle, plus directed checks.
module prg_event_unit_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref32_lvl = 1'b0;
    logic [2:0] osc_mode = 3'b000;
    logic [3:0] rate_sel = 4'd0;
    logic       ctl_wr = 1'b0;
    logic [4:0] ctl_wdata = 5'd0;
    logic       alarm_evt = 1'b0;
    logic       update_evt = 1'b0;
    logic       stat_rd = 1'b0;
    logic       stat_wr = 1'b0;
    logic       k32_wdata = 1'b0;
    logic [4:0] ctl_rdata;
    logic [7:0] stat_rdata;
    logic       sqw_out;
    logic       irq_n;
    int         errors = 0;
    int         checks = 0;
    logic [1:0] ref_ph = 2'd0;

    always #2 clk = ~clk;

    prg_event_unit u_prg_event_unit (
        .clk(clk), .rst_n(rst_n), .ref32_lvl(ref32_lvl), .osc_mode(osc_mode),
        .rate_sel(rate_sel), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .alarm_evt(alarm_evt), .update_evt(update_evt),
        .stat_rd(stat_rd), .stat_wr(stat_wr), .k32_wdata(k32_wdata),
        .stat_rdata(stat_rdata), .sqw_out(sqw_out), .irq_n(irq_n)
    );

    // Reference waveform: four clk cycles per period.
    always begin
        @(posedge clk);
        #1;
        ref_ph    = ref_ph + 2'd1;
        ref32_lvl = ref_ph[1];
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference periods of one tap period for a rate code.
    function automatic int period_ticks(input int code);
        int f;
        if (code == 1) f = 256;
        else if (code == 2) f = 128;
        else f = 8192 >> (code - 3);
        return 32768 / f;
    endfunction

    // ---------------- reference model ----------------
    bit       m_ok = 0;
    bit       m_s1, m_s2, m_pf, m_af, m_uf, m_req, m_k32;
    bit [4:0] m_ctl;
    int       m_cnt;

    always @(posedge clk) begin
        bit tick, run, per, keep, pf_n, af_n, uf_n;
        int p;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_pf = 0; m_af = 0; m_uf = 0; m_req = 0;
            m_k32 = 0; m_ctl = 0; m_cnt = 0; m_ok = 1;
        end else begin
            tick = m_s1 && !m_s2;
            run  = (osc_mode == 3'b010) || (osc_mode == 3'b011);
            per  = 0;
            if (run && tick && rate_sel != 0) begin
                p   = period_ticks(int'(rate_sel));
                per = (m_cnt % p) == p - 1;
            end
            keep  = !stat_rd;
            pf_n  = (m_pf && keep) || per;
            af_n  = (m_af && keep) || alarm_evt;
            uf_n  = (m_uf && keep) || update_evt;
            m_req = (m_req && keep) || (pf_n && m_ctl[3]) || (af_n && m_ctl[2])
                  || (uf_n && m_ctl[1] && !m_ctl[4]);
            m_pf = pf_n; m_af = af_n; m_uf = uf_n;
            if (osc_mode != 3'b011) m_k32 = 0;
            else if (stat_wr) m_k32 = k32_wdata;
            if (ctl_wr) begin
                m_ctl = ctl_wdata;
                if (ctl_wdata[4]) m_ctl[1] = 0;
            end
            if (!run) m_cnt = 0;
            else if (tick) m_cnt = (m_cnt + 1) % 16384;
            m_s2 = m_s1;
            m_s1 = ref32_lvl;
        end
    end

    // Per-cycle comparison against the model, away from the rising edge.
    always @(negedge clk) begin
        bit e_sqw;
        int p;
        string tag;
        if (m_ok) begin
            if (!m_ctl[0]) begin e_sqw = 0; tag = "R3 sqw"; end
            else if (m_k32) begin e_sqw = m_s1; tag = "R6 sqw"; end
            else if (rate_sel == 0) begin e_sqw = 0; tag = "R1 sqw"; end
            else begin
                p = period_ticks(int'(rate_sel));
                e_sqw = (m_cnt % p) >= p / 2;
                tag = "R1 sqw";
            end
            check(tag, int'(sqw_out), int'(e_sqw));
            check("R8 status", int'(stat_rdata),
                  int'({m_req, m_pf, m_af, m_uf, 1'b0, m_k32, 2'b00}));
            check("R7 irq_n", int'(irq_n), int'(!m_req));
            check("R9 control", int'(ctl_rdata), int'(m_ctl));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step();
        @(posedge clk);
        #1;
        ctl_wr = 0; stat_rd = 0; stat_wr = 0; alarm_evt = 0; update_evt = 0;
    endtask

    task automatic wr_ctl(input logic [4:0] v);
        step(); ctl_wr = 1; ctl_wdata = v; step();
    endtask

    task automatic set_cfg(input logic [2:0] o, input logic [3:0] r);
        step(); osc_mode = o; rate_sel = r; step();
    endtask

    task automatic rd_stat();
        step(); stat_rd = 1; step();
    endtask

    // Count rises of the periodic flag (use_pf) or sqw_out over a window.
    task automatic count_rises(input int window, input bit use_pf, output int n);
        bit prev, cur, pend;
        n = 0;
        @(negedge clk);
        prev = use_pf ? stat_rdata[6] : sqw_out;
        pend = use_pf && prev;
        for (int i = 0; i < window; i++) begin
            @(posedge clk);
            #1;
            stat_rd = pend;
            pend = 0;
            @(negedge clk);
            cur = use_pf ? stat_rdata[6] : sqw_out;
            if (cur && !prev) n++;
            prev = cur;
            if (use_pf && stat_rdata[6]) pend = 1;
        end
        step();
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        report();
        $finish;
    end

    initial begin
        int n;
        repeat (3) step();
        rst_n = 1;
        step();
        @(negedge clk);
        check("R11 reset status", int'(stat_rdata), 0);
        check("R11 reset control", int'(ctl_rdata), 0);
        check("R11 reset irq_n", int'(irq_n), 1);
        check("R11 reset sqw", int'(sqw_out), 0);

        // R1 / R2: rate taps and periodic events
        wr_ctl(5'b01001);
        set_cfg(3'b010, 4'd3);
        count_rises(160, 0, n);  check("R1 code3 sqw rises", n, 10);
        count_rises(160, 1, n);  check("R2 code3 periodic events", n, 10);
        set_cfg(3'b010, 4'd5);
        count_rises(640, 1, n);  check("R2 code5 periodic events", n, 10);
        set_cfg(3'b010, 4'd1);
        count_rises(1024, 0, n); check("R1 code1 alias sqw rises", n, 2);
        set_cfg(3'b010, 4'd8);
        count_rises(1024, 0, n); check("R1 code8 sqw rises", n, 2);
        set_cfg(3'b010, 4'd2);
        count_rises(2048, 0, n); check("R1 code2 alias sqw rises", n, 2);
        set_cfg(3'b010, 4'd0);
        count_rises(300, 0, n);  check("R1 code0 sqw rises", n, 0);
        count_rises(300, 1, n);  check("R2 code0 periodic events", n, 0);
        set_cfg(3'b010, 4'd15);
        count_rises(65536, 1, n); check("R2 code15 periodic events", n, 1);

        // R3: square-wave enable off
        wr_ctl(5'b01000);
        set_cfg(3'b010, 4'd3);
        count_rises(160, 0, n);  check("R3 sqw rises with enable off", n, 0);

        // R4: divider held
        wr_ctl(5'b01001);
        set_cfg(3'b110, 4'd3);
        count_rises(160, 1, n);  check("R4 mode 110 periodic events", n, 0);
        count_rises(160, 0, n);  check("R4 mode 110 sqw rises", n, 0);
        set_cfg(3'b000, 4'd3);
        count_rises(160, 1, n);  check("R4 mode 000 periodic events", n, 0);

        // R5: 32 kHz enable only in the writable mode
        set_cfg(3'b010, 4'd0);
        step(); stat_wr = 1; k32_wdata = 1; step();
        @(negedge clk);
        check("R5 write outside 011", int'(stat_rdata[2]), 0);
        set_cfg(3'b011, 4'd0);
        step(); stat_wr = 1; k32_wdata = 1; step();
        @(negedge clk);
        check("R5 write in 011", int'(stat_rdata[2]), 1);
        check("R8 unused bits zero", int'(stat_rdata & 8'h0B), 0);

        // R6: pass-through with periodic timing unchanged
        set_cfg(3'b011, 4'd5);
        count_rises(40, 0, n);   check("R6 pass-through sqw rises", n, 10);
        count_rises(640, 1, n);  check("R6 periodic events in pass-through", n, 10);
        @(negedge clk);
        check("R8 read keeps 32k enable", int'(stat_rdata[2]), 1);
        set_cfg(3'b010, 4'd0);
        @(negedge clk);
        check("R5 leaving 011 clears", int'(stat_rdata[2]), 0);

        // R7 / R8: alarm with and without enable
        wr_ctl(5'b00100);
        rd_stat();
        step(); alarm_evt = 1; step();
        @(negedge clk);
        check("R7 alarm flag", int'(stat_rdata[5]), 1);
        check("R7 aggregate set", int'(stat_rdata[7]), 1);
        check("R7 irq_n low", int'(irq_n), 0);
        rd_stat();
        @(negedge clk);
        check("R8 read clears flags", int'(stat_rdata[7:4]), 0);
        check("R8 read releases irq", int'(irq_n), 1);
        wr_ctl(5'b00000);
        step(); alarm_evt = 1; step();
        @(negedge clk);
        check("R7 alarm flag disabled", int'(stat_rdata[5]), 1);
        check("R7 no aggregate when disabled", int'(stat_rdata[7]), 0);
        check("R7 irq_n high when disabled", int'(irq_n), 1);

        // R10: event in the same cycle as the read
        step(); alarm_evt = 1; stat_rd = 1; step();
        @(negedge clk);
        check("R10 alarm survives read", int'(stat_rdata[5]), 1);
        rd_stat();

        // R9: transfer inhibit and update interrupt
        wr_ctl(5'b10010);
        @(negedge clk);
        check("R9 inhibit write drops update enable", int'(ctl_rdata), 5'b10000);
        wr_ctl(5'b00010);
        step(); update_evt = 1; step();
        @(negedge clk);
        check("R9 update requests when allowed", int'(irq_n), 0);
        rd_stat();
        wr_ctl(5'b10010);
        step(); update_evt = 1; step();
        @(negedge clk);
        check("R9 update flag under inhibit", int'(stat_rdata[4]), 1);
        check("R9 no request under inhibit", int'(stat_rdata[7]), 0);
        check("R9 irq_n under inhibit", int'(irq_n), 1);
        rd_stat();
        step();
        report();
        $finish;
    end
endmodule